// File: doc/BRIEF.md
# Cross-Domain Mailbox Register

This block carries a single data word from one clock domain to another, beside a FIFO rather than through it. A writer issues a mailbox write on its own clock. The word is captured in a holding register, and an active-low pending flag drops on the writer side. While that flag is low, the writer cannot overwrite the word.

On the reader side, a synchronised copy of the write event raises a mail-valid status. A mailbox read then acknowledges the word. The acknowledge travels back to the writer domain, and there it releases the pending flag. The reader's data output is a two-way selector. With the mailbox select high it shows the held mail word. With the mailbox select low it shows the FIFO output register, which reaches this block as a plain input.

The two clocks may be unrelated. Each domain has its own synchronous active-low reset.

Top module: `xdom_mailbox`

## Requirements
- R1: A writer-clock rising edge with `w_sel_n` low, `w_en` high, `w_dir` high (1 = write), `w_mbx` high and `w_mail_n` high stores `w_data` as the mail word, and `w_mail_n` is low after that edge.
- R2: While `w_mail_n` is low, further mailbox writes are ignored and the stored mail word is unchanged.
- R3: A writer or reader access takes effect only on an edge where that side's select is low and its enable is high. Otherwise the flag and the mail-valid status are unchanged.
- R4: A writer access with `w_dir` low or `w_mbx` low leaves the mailbox and `w_mail_n` untouched.
- R5: After a stored write, `r_mail_vld` rises within four reader-clock edges. It then stays high until a mailbox read.
- R6: A reader-clock edge with `r_sel_n` low, `r_en` high, `r_mbx` high and `r_mail_vld` high clears `r_mail_vld` after that edge. `w_mail_n` returns high within five writer-clock edges of the read, and never before a read.
- R7: A mailbox read while `r_mail_vld` is low has no effect: the flag stays high, the valid status stays low, and the next write and read complete normally.
- R8: `r_data` equals the mail word when `r_mbx` is high and equals `fifo_q` when `r_mbx` is low.
- R9: During reset, `w_mail_n` goes high, `r_mail_vld` goes low and the mail word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer clock |
| wrst_n | input | 1 | Writer-domain synchronous reset, active low |
| w_sel_n | input | 1 | Writer select, active low |
| w_en | input | 1 | Writer enable |
| w_dir | input | 1 | Writer direction, 1 = write |
| w_mbx | input | 1 | Writer mailbox select |
| w_data | input | 36 | Word to post |
| w_mail_n | output | 1 | Mail pending flag, low while a word is unread |
| rclk | input | 1 | Reader clock |
| rrst_n | input | 1 | Reader-domain synchronous reset, active low |
| r_sel_n | input | 1 | Reader select, active low |
| r_en | input | 1 | Reader enable |
| r_mbx | input | 1 | Reader mailbox select, also steers `r_data` |
| fifo_q | input | 36 | FIFO output register contents |
| r_data | output | 36 | Reader data: mail word or FIFO word |
| r_mail_vld | output | 1 | Unread mail present, reader domain |

## Verification
On every edge of its own clock, the checker confirms the following:
- a qualified write lowers the flag;
- the flag cannot fall without a qualified write;
- a read of valid mail drops the valid status;
- valid mail persists until it is read;
- both resets establish their idle values.

The bench scenarios cover the properties that span the two domains and run under unrelated clock periods. These are the latency bounds, the rule that the flag returns only after a read, and the retention of the first word when a second write is blocked. The bench also covers the data selector, an empty read, and the loss-free delivery of a series of words.

// File: rtl/mbx_pkg.sv
// Package: shared constants for the cross-domain mailbox.
// Assumes: consumers pass these as parameter defaults only.
package mbx_pkg;
    localparam int unsigned MBX_WIDTH_DEF = 36;
    localparam int unsigned MBX_SYNC_DEF  = 2;
endpackage

// File: rtl/mbx_sync.sv
// Module: mbx_sync
// Carries one level signal into the clk domain through a flop chain.
// Assumes: the input changes at most once per several destination cycles
// (a toggle), so no multi-bit coherence is needed.
module mbx_sync #(
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the asynchronous level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/mbx_wr_side.sv
// Module: mbx_wr_side
// Writer-domain half: decodes a qualified mailbox write, holds the word,
// drives the active-low pending flag and flips a write toggle. The flag is
// released only when the reader's acknowledge toggle, synchronised here,
// differs from the last one seen.
// Assumes: ack_tgl_in comes from the reader clock domain.
module mbx_wr_side #(
    parameter int unsigned W    = mbx_pkg::MBX_WIDTH_DEF,
    parameter int unsigned SYNC = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         w_sel_n,
    input  logic         w_en,
    input  logic         w_dir,
    input  logic         w_mbx,
    input  logic [W-1:0] w_data,
    input  logic         ack_tgl_in,
    output logic [W-1:0] mail_q,
    output logic         wr_tgl,
    output logic         mail_n
);
    logic ack_sync;
    logic ack_seen;
    logic wr_take;
    logic ack_new;

    mbx_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (ack_tgl_in),
        .q     (ack_sync)
    );

    // Qualify a write: selected, enabled, write direction, mailbox, flag free.
    always_comb begin
        wr_take = !w_sel_n && w_en && w_dir && w_mbx && mail_n;
        ack_new = (ack_sync != ack_seen);
    end

    // Capture the mail word only on an accepted write.
    always_ff @(posedge wclk) begin
        if (!wrst_n)      mail_q <= '0;
        else if (wr_take) mail_q <= w_data;
    end

    // Pending flag, write toggle and acknowledge bookkeeping.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            mail_n   <= 1'b1;
            wr_tgl   <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            if (wr_take) begin
                mail_n <= 1'b0;
                wr_tgl <= ~wr_tgl;
            end else if (ack_new) begin
                mail_n   <= 1'b1;
                ack_seen <= ack_sync;
            end
        end
    end
endmodule

// File: rtl/mbx_rd_side.sv
// Module: mbx_rd_side
// Reader-domain half: synchronises the write toggle, presents mail-valid,
// and on a qualified mailbox read of valid mail flips the acknowledge toggle.
// Assumes: wr_tgl_in comes from the writer clock domain and cannot flip again
// before this side acknowledges.
module mbx_rd_side #(
    parameter int unsigned SYNC = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic rclk,
    input  logic rrst_n,
    input  logic r_sel_n,
    input  logic r_en,
    input  logic r_mbx,
    input  logic wr_tgl_in,
    output logic ack_tgl,
    output logic mail_vld
);
    logic wr_sync;
    logic rd_seen;
    logic rd_take;

    mbx_sync #(.STAGES(SYNC)) u_wr_sync (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wr_tgl_in),
        .q     (wr_sync)
    );

    // Valid mail is an unmatched write toggle; a read counts only then.
    always_comb begin
        mail_vld = (wr_sync != rd_seen);
        rd_take  = !r_sel_n && r_en && r_mbx && mail_vld;
    end

    // Consume the mail and send the acknowledge toggle back.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rd_seen <= 1'b0;
            ack_tgl <= 1'b0;
        end else if (rd_take) begin
            rd_seen <= wr_sync;
            ack_tgl <= ~ack_tgl;
        end
    end
endmodule

// File: rtl/xdom_mailbox.sv
// Module: xdom_mailbox (top)
// Single-word mailbox between two unrelated clocks, with the reader data
// selector between the mail word and the external FIFO output register.
// Assumes: each reset is held for several cycles of its own clock, and both
// resets are applied together.
module xdom_mailbox #(
    parameter int unsigned W    = mbx_pkg::MBX_WIDTH_DEF,
    parameter int unsigned SYNC = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         w_sel_n,
    input  logic         w_en,
    input  logic         w_dir,
    input  logic         w_mbx,
    input  logic [W-1:0] w_data,
    output logic         w_mail_n,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         r_sel_n,
    input  logic         r_en,
    input  logic         r_mbx,
    input  logic [W-1:0] fifo_q,
    output logic [W-1:0] r_data,
    output logic         r_mail_vld
);
    logic [W-1:0] mail_q;
    logic         wr_tgl;
    logic         ack_tgl;

    mbx_wr_side #(.W(W), .SYNC(SYNC)) u_wr (
        .wclk       (wclk),
        .wrst_n     (wrst_n),
        .w_sel_n    (w_sel_n),
        .w_en       (w_en),
        .w_dir      (w_dir),
        .w_mbx      (w_mbx),
        .w_data     (w_data),
        .ack_tgl_in (ack_tgl),
        .mail_q     (mail_q),
        .wr_tgl     (wr_tgl),
        .mail_n     (w_mail_n)
    );

    mbx_rd_side #(.SYNC(SYNC)) u_rd (
        .rclk      (rclk),
        .rrst_n    (rrst_n),
        .r_sel_n   (r_sel_n),
        .r_en      (r_en),
        .r_mbx     (r_mbx),
        .wr_tgl_in (wr_tgl),
        .ack_tgl   (ack_tgl),
        .mail_vld  (r_mail_vld)
    );

    // Reader output selector: mail word or FIFO output register.
    always_comb begin
        r_data = r_mbx ? mail_q : fifo_q;
    end
endmodule

// File: rtl/xdom_mailbox_chk.sv
// Module: xdom_mailbox_chk
// Per-cycle properties of the mailbox, attached to the top by bind.
// Assumes: port names match the top module.
module xdom_mailbox_chk (
    input logic wclk,
    input logic wrst_n,
    input logic w_sel_n,
    input logic w_en,
    input logic w_dir,
    input logic w_mbx,
    input logic w_mail_n,
    input logic rclk,
    input logic rrst_n,
    input logic r_sel_n,
    input logic r_en,
    input logic r_mbx,
    input logic r_mail_vld
);
    logic wr_fire;
    logic rd_fire;

    assign wr_fire = !w_sel_n && w_en && w_dir && w_mbx && w_mail_n;
    assign rd_fire = !r_sel_n && r_en && r_mbx;

    a_r1_write_lowers_flag: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_fire |=> !w_mail_n);

    a_r3_flag_falls_only_on_write: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_mail_n && !wr_fire) |=> w_mail_n);

    a_r5_valid_held_until_read: assert property (@(posedge rclk) disable iff (!rrst_n)
        (r_mail_vld && !rd_fire) |=> r_mail_vld);

    a_r6_read_clears_valid: assert property (@(posedge rclk) disable iff (!rrst_n)
        (r_mail_vld && rd_fire) |=> !r_mail_vld);

    a_r9_wr_reset_idle: assert property (@(posedge wclk)
        !wrst_n |=> w_mail_n);

    a_r9_rd_reset_idle: assert property (@(posedge rclk)
        !rrst_n |=> !r_mail_vld);
endmodule

bind xdom_mailbox xdom_mailbox_chk u_chk (.*);

// File: tb/xdom_mailbox_bench.sv
// Directed bench for xdom_mailbox with unrelated writer and reader clocks.
module xdom_mailbox_bench;
    localparam int unsigned W = 36;

    logic         wclk = 1'b0;
    logic         rclk = 1'b0;
    logic         wrst_n, rrst_n;
    logic         w_sel_n, w_en, w_dir, w_mbx;
    logic [W-1:0] w_data;
    logic         w_mail_n;
    logic         r_sel_n, r_en, r_mbx;
    logic [W-1:0] fifo_q;
    logic [W-1:0] r_data;
    logic         r_mail_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2   wclk = ~wclk;   // 250 MHz writer clock
    always #3.5 rclk = ~rclk;   // unrelated reader clock

    xdom_mailbox #(.W(W)) u_xdom_mailbox (
        .wclk(wclk), .wrst_n(wrst_n), .w_sel_n(w_sel_n), .w_en(w_en),
        .w_dir(w_dir), .w_mbx(w_mbx), .w_data(w_data), .w_mail_n(w_mail_n),
        .rclk(rclk), .rrst_n(rrst_n), .r_sel_n(r_sel_n), .r_en(r_en),
        .r_mbx(r_mbx), .fifo_q(fifo_q), .r_data(r_data), .r_mail_vld(r_mail_vld)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One writer-side access pulse with the given qualifiers.
    task automatic wr_pulse(input logic sel_n, input logic en, input logic dir,
                            input logic mbx, input logic [W-1:0] d);
        @(negedge wclk);
        w_sel_n = sel_n; w_en = en; w_dir = dir; w_mbx = mbx; w_data = d;
        @(negedge wclk);
        w_sel_n = 1'b1; w_en = 1'b0; w_dir = 1'b0; w_mbx = 1'b0;
    endtask

    // One reader-side mailbox pulse; returns data seen during the pulse.
    task automatic rd_pulse(input logic sel_n, input logic en, output logic [W-1:0] seen);
        @(negedge rclk);
        r_sel_n = sel_n; r_en = en; r_mbx = 1'b1;
        #1 seen = r_data;
        @(negedge rclk);
        r_sel_n = 1'b1; r_en = 1'b0; r_mbx = 1'b0;
    endtask

    task automatic wait_vld(input string tag);
        int n = 0;
        while (!r_mail_vld && n < 20) begin
            @(negedge rclk);
            n++;
        end
        chk({tag, " valid raised"}, r_mail_vld, 1'b1);
        chk({tag, " valid within 4 edges"}, (n <= 4), 1'b1);
    endtask

    task automatic wait_flag(input string tag);
        int n = 0;
        while (!w_mail_n && n < 20) begin
            @(negedge wclk);
            n++;
        end
        chk({tag, " flag released"}, w_mail_n, 1'b1);
        chk({tag, " flag within 5 edges"}, (n <= 5), 1'b1);
    endtask

    task automatic t_reset();
        wrst_n = 1'b0; rrst_n = 1'b0;
        repeat (6) @(negedge rclk);
        r_mbx = 1'b1;
        #1;
        chk("R9 flag high in reset", w_mail_n, 1'b1);
        chk("R9 valid low in reset", r_mail_vld, 1'b0);
        chk("R9 mail word cleared", r_data, '0);
        r_mbx = 1'b0;
        wrst_n = 1'b1; rrst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic t_basic();
        logic [W-1:0] seen;
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_1234_5678);
        chk("R1 flag low after write", w_mail_n, 1'b0);
        wait_vld("R5 basic");
        repeat (30) @(negedge wclk);
        chk("R6 flag stays low without read", w_mail_n, 1'b0);
        chk("R5 valid held without read", r_mail_vld, 1'b1);
        rd_pulse(1'b0, 1'b1, seen);
        chk("R1 mail word delivered", seen, 36'h9_1234_5678);
        chk("R6 valid cleared by read", r_mail_vld, 1'b0);
        wait_flag("R6 basic");
    endtask

    task automatic t_blocked();
        logic [W-1:0] seen;
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'hA_AAAA_0001);
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'h5_5555_0002);
        chk("R2 flag low after blocked write", w_mail_n, 1'b0);
        wait_vld("R2 blocked");
        @(negedge rclk); r_mbx = 1'b1; #1;
        chk("R2 first word kept", r_data, 36'hA_AAAA_0001);
        r_mbx = 1'b0;
        rd_pulse(1'b0, 1'b1, seen);
        chk("R2 first word read", seen, 36'hA_AAAA_0001);
        wait_flag("R2 blocked");
        repeat (10) @(negedge rclk);
        chk("R2 blocked word never arrives", r_mail_vld, 1'b0);
    endtask

    task automatic t_ignored();
        logic [W-1:0] seen;
        wr_pulse(1'b1, 1'b1, 1'b1, 1'b1, 36'h1);
        wr_pulse(1'b0, 1'b0, 1'b1, 1'b1, 36'h2);
        chk("R3 unselected or disabled write ignored", w_mail_n, 1'b1);
        wr_pulse(1'b0, 1'b1, 1'b0, 1'b1, 36'h3);
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b0, 36'h4);
        chk("R4 read-direction or FIFO write ignored", w_mail_n, 1'b1);
        repeat (8) @(negedge rclk);
        chk("R4 no valid from ignored writes", r_mail_vld, 1'b0);
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'h7_0000_00C3);
        wait_vld("R3 setup");
        rd_pulse(1'b1, 1'b1, seen);
        rd_pulse(1'b0, 1'b0, seen);
        repeat (12) @(negedge wclk);
        chk("R3 unqualified read keeps valid", r_mail_vld, 1'b1);
        chk("R3 unqualified read keeps flag low", w_mail_n, 1'b0);
        rd_pulse(1'b0, 1'b1, seen);
        chk("R3 real read data", seen, 36'h7_0000_00C3);
        wait_flag("R3");
    endtask

    task automatic t_empty_read();
        logic [W-1:0] seen;
        rd_pulse(1'b0, 1'b1, seen);
        repeat (10) @(negedge wclk);
        chk("R7 flag high after empty read", w_mail_n, 1'b1);
        chk("R7 valid low after empty read", r_mail_vld, 1'b0);
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_0F0F_0F0F);
        wait_vld("R7 after empty read");
        rd_pulse(1'b0, 1'b1, seen);
        chk("R7 next word intact", seen, 36'hF_0F0F_0F0F);
        wait_flag("R7");
    endtask

    task automatic t_mux();
        wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 36'h3_CAFE_0000);
        wait_vld("R8 setup");
        @(negedge rclk);
        fifo_q = 36'h8_BEEF_1111; r_mbx = 1'b0; #1;
        chk("R8 FIFO word when mailbox deselected", r_data, 36'h8_BEEF_1111);
        fifo_q = 36'h0_0000_FFFF; #1;
        chk("R8 FIFO word follows input", r_data, 36'h0_0000_FFFF);
        r_mbx = 1'b1; #1;
        chk("R8 mail word when mailbox selected", r_data, 36'h3_CAFE_0000);
        r_mbx = 1'b0;
        begin
            logic [W-1:0] seen;
            rd_pulse(1'b0, 1'b1, seen);
        end
        wait_flag("R8");
    endtask

    task automatic t_series();
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] word;
            logic [W-1:0] seen;
            word = 36'h1_0000_0000 * (i + 1) + 36'h0_0000_0101 * i;
            wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, word);
            chk("R1 series flag low", w_mail_n, 1'b0);
            wait_vld("R5 series");
            rd_pulse(1'b0, 1'b1, seen);
            chk("R6 series word no loss", seen, word);
            wait_flag("R6 series");
        end
    endtask

    initial begin
        wrst_n = 1'b0; rrst_n = 1'b0;
        w_sel_n = 1'b1; w_en = 1'b0; w_dir = 1'b0; w_mbx = 1'b0; w_data = '0;
        r_sel_n = 1'b1; r_en = 1'b0; r_mbx = 1'b0; fifo_q = '0;
        t_reset();
        t_basic();
        t_blocked();
        t_ignored();
        t_empty_read();
        t_mux();
        t_series();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule